// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is a slave serial audio port for a stereo stream. An external master drives the bit clock and the word-select line. The port deserialises the left and right words arriving on its data input and serialises a pair of words onto its data output, both in the same frame. A 3-bit format code selects one of three framings. In the first, the word starts one bit after the word-select change. In the second, the word starts on the first bit of the slot. In the third, the word ends on the last bit of the slot and is 16, 18 or 20 bits long.

The bit clock, word select and serial input are brought into the system clock domain through synchronisers. All slot timing is derived from the detected bit-clock edges. Received words come out MSB-aligned in a 20-bit field with a one-cycle strobe per frame. Words to transmit are taken from two parallel inputs at the start of each left slot.

Top module: `sap_port`

## Requirements
- R1: The format code selects the framing: 000 delayed-MSB (MSB one bit after the word-select change), 001 end-aligned 16 bits, 010 end-aligned 18 bits, 011 end-aligned 20 bits, 100 start-aligned (MSB in the first bit of the slot). With codes 101, 110 and 111 the port stores no word, never pulses `rx_valid` and holds `sdo` low.
- R2: Word select low marks the left slot and high marks the right slot. `ws` and `sdi` are sampled on rising `sck` edges.
- R3: In code 000 the receiver takes the 20 bits that follow the first rising edge at which the new word-select level is seen, MSB first.
- R4: In code 100 the receiver takes the first 20 bits of the slot, MSB first, starting at the first rising edge that sees the new word-select level.
- R5: In codes 001/010/011 the receiver takes the last N bits (N = 16/18/20) before the word-select change. It returns them in bits 19 down to 20-N with the lower bits zero.
- R6: `rx_valid` is a one-cycle pulse, issued once per frame after the right word completes, when a left word of the same frame was received. `rx_left` and `rx_right` change only with that pulse.
- R7: `sdo` changes only after a falling `sck` edge. It places the transmitted word in the same bit positions of the slot that the receiver uses for the active format.
- R8: In the end-aligned codes the transmitter places the MSB using the length, in bit clocks, of the previous slot. It sends zeros until one complete slot has been measured.
- R9: Every slot bit outside the active word window is driven low on `sdo`.
- R10: `tx_left` and `tx_right` are both captured at the start of each left slot. Changes after that point do not affect the frame in progress.
- R11: After reset `sdo`, `rx_valid`, `rx_left` and `rx_right` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt | input | 3 | Framing code (see R1) |
| sck | input | 1 | Serial bit clock from the master |
| ws | input | 1 | Word select from the master, low = left |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tx_left | input | WORD_W | Left word to send, MSB-aligned |
| tx_right | input | WORD_W | Right word to send, MSB-aligned |
| rx_left | output | WORD_W | Last received left word, MSB-aligned |
| rx_right | output | WORD_W | Last received right word, MSB-aligned |
| rx_valid | output | 1 | One-cycle strobe when a new word pair is out |

## Verification
The assertions assume that each `sck` phase lasts several system clocks, longer than the synchroniser delay. They also assume that `ws` and `sdi` change only next to a falling `sck` edge, that every slot is at least as long as the word and no longer than SLOT_MAX, and that `fmt` changes only while reset is held. The bench acts as the master with eight system clocks per bit-clock phase. It moves `ws` and `sdi` only in the cycle where it lowers `sck`, keeps slots of 24 or 32 bits, and applies each format from a fresh reset with a preamble slot before the checked frames.

// File: rtl/sap_pkg.sv
// Shared constants and helpers for the serial audio port.
// Assumes the format field is 3 bits wide; codes above 4 are unused.
package sap_pkg;
    localparam logic [2:0] FMT_I2S  = 3'd0;
    localparam logic [2:0] FMT_RJ16 = 3'd1;
    localparam logic [2:0] FMT_RJ18 = 3'd2;
    localparam logic [2:0] FMT_RJ20 = 3'd3;
    localparam logic [2:0] FMT_LJ   = 3'd4;

    // True for any code that selects a framing
    function automatic logic fmt_known(input logic [2:0] f);
        return f <= FMT_LJ;
    endfunction

    // True for the end-aligned codes
    function automatic logic fmt_is_rj(input logic [2:0] f);
        return (f == FMT_RJ16) || (f == FMT_RJ18) || (f == FMT_RJ20);
    endfunction

    // Word length used by the end-aligned codes
    function automatic logic [4:0] rj_bits(input logic [2:0] f);
        case (f)
            FMT_RJ16: return 5'd16;
            FMT_RJ18: return 5'd18;
            default:  return 5'd20;
        endcase
    endfunction
endpackage

// File: rtl/sap_sync.sv
// Brings bit clock, word select and serial data into the system clock
// domain and flags rising and falling bit-clock edges for one cycle.
// Assumes each bit-clock phase is longer than STAGES+1 system clocks.
module sap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic ws,
    input  logic sdi,
    output logic rise_evt,
    output logic fall_evt,
    output logic ws_s,
    output logic sdi_s
);
    logic [STAGES:0] sck_q;
    logic [STAGES:0] ws_q;
    logic [STAGES:0] sdi_q;
    logic            sck_last;

    assign sck_q[0] = sck;
    assign ws_q[0]  = ws;
    assign sdi_q[0] = sdi;

    for (genvar st = 0; st < STAGES; st++) begin : g_stage
        // One synchroniser rank for all three inputs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sck_q[st+1] <= 1'b0;
                ws_q[st+1]  <= 1'b0;
                sdi_q[st+1] <= 1'b0;
            end else begin
                sck_q[st+1] <= sck_q[st];
                ws_q[st+1]  <= ws_q[st];
                sdi_q[st+1] <= sdi_q[st];
            end
        end
    end

    // Previous synchronised bit-clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= sck_q[STAGES];
    end

    assign rise_evt = sck_q[STAGES] & ~sck_last;
    assign fall_evt = ~sck_q[STAGES] & sck_last;
    assign ws_s     = ws_q[STAGES];
    assign sdi_s    = sdi_q[STAGES];
endmodule

// File: rtl/sap_rx.sv
// Receive half: tracks slots on rising bit-clock edges and assembles the
// left and right words in the chosen framing, MSB-aligned, zero filled.
// The delayed-MSB code is handled as start-aligned with word select seen
// one bit later. Assumes WORD_W >= 20 and SLOT_MAX >= WORD_W.
module sap_rx
    import sap_pkg::*;
#(
    parameter int WORD_W   = 20,
    parameter int SLOT_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt,
    input  logic              rise_evt,
    input  logic              ws_s,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid
);
    localparam int CNT_W = $clog2(SLOT_MAX + 1);
    localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    logic              ws_d1;
    logic              eff_last;
    logic              slot_live;
    logic              left_ok;
    logic [CNT_W-1:0]  idx;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] left_hold;

    logic              ws_eff;
    logic              slot_edge;
    logic [WORD_W-1:0] bit_mask;
    logic [CNT_W-1:0]  rj_n;
    logic [WORD_W-1:0] rj_word;
    logic [WORD_W-1:0] done_word;

    // Effective slot boundary and the word that closes with it
    always_comb begin
        ws_eff    = (fmt == FMT_I2S) ? ws_d1 : ws_s;
        slot_edge = ws_eff ^ eff_last;
        bit_mask  = TOP_BIT >> idx;
        rj_n      = CNT_W'(rj_bits(fmt));
        rj_word   = sr << (CNT_W'(WORD_W) - rj_n);
        done_word = fmt_is_rj(fmt) ? rj_word : acc;
    end

    // Slot tracking, bit capture and word hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_d1     <= 1'b0;
            eff_last  <= 1'b0;
            slot_live <= 1'b0;
            left_ok   <= 1'b0;
            idx       <= '0;
            acc       <= '0;
            sr        <= '0;
            left_hold <= '0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise_evt) begin
                ws_d1    <= ws_s;
                eff_last <= ws_eff;
                sr       <= {sr[WORD_W-2:0], sdi_s};
                if (slot_edge) begin
                    if (slot_live && fmt_known(fmt)) begin
                        if (!eff_last) begin
                            left_hold <= done_word;
                            left_ok   <= 1'b1;
                        end else if (left_ok) begin
                            rx_left  <= left_hold;
                            rx_right <= done_word;
                            rx_valid <= 1'b1;
                            left_ok  <= 1'b0;
                        end
                    end
                    slot_live <= 1'b1;
                    idx       <= CNT_W'(1);
                    acc       <= sdi_s ? TOP_BIT : '0;
                end else begin
                    if (sdi_s) acc <= acc | bit_mask;
                    if (idx != CNT_W'(SLOT_MAX)) idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sap_tx.sv
// Transmit half: tracks slots on falling bit-clock edges and drives one
// bit per bit clock. End-aligned words are placed from the length of the
// previous slot. Both words are taken at the start of the left slot.
// Assumes SLOT_MAX >= WORD_W >= 20.
module sap_tx
    import sap_pkg::*;
#(
    parameter int WORD_W   = 20,
    parameter int SLOT_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt,
    input  logic              fall_evt,
    input  logic              ws_s,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic              sdo
);
    localparam int CNT_W = $clog2(SLOT_MAX + 1);
    localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    logic              ws_d1;
    logic              eff_last;
    logic              started;
    logic              len_ok;
    logic              cur_right;
    logic [CNT_W-1:0]  pos;
    logic [CNT_W-1:0]  len;
    logic [WORD_W-1:0] hold_l;
    logic [WORD_W-1:0] hold_r;

    logic              ws_eff;
    logic              slot_edge;
    logic [CNT_W-1:0]  p_n;
    logic [CNT_W-1:0]  len_n;
    logic              lok_n;
    logic [WORD_W-1:0] word_n;
    logic [CNT_W-1:0]  rj_n;
    logic [CNT_W-1:0]  k;
    logic              bit_n;

    // Next slot position and the bit that belongs there
    always_comb begin
        ws_eff    = (fmt == FMT_I2S) ? ws_d1 : ws_s;
        slot_edge = ws_eff ^ eff_last;
        if (slot_edge)                       p_n = '0;
        else if (pos == CNT_W'(SLOT_MAX))    p_n = pos;
        else                                 p_n = pos + 1'b1;
        len_n  = slot_edge ? pos + 1'b1 : len;
        lok_n  = slot_edge ? started : len_ok;
        word_n = slot_edge ? (ws_eff ? hold_r : tx_left)
                           : (cur_right ? hold_r : hold_l);
        rj_n   = CNT_W'(rj_bits(fmt));
        if (fmt_is_rj(fmt)) begin
            if (lok_n && (len_n >= rj_n) && (p_n >= len_n - rj_n))
                k = p_n - (len_n - rj_n);
            else
                k = '1;
        end else begin
            k = p_n;
        end
        bit_n = fmt_known(fmt) && (|(word_n & (TOP_BIT >> k)));
    end

    // Slot tracking, word capture and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_d1     <= 1'b0;
            eff_last  <= 1'b0;
            started   <= 1'b0;
            len_ok    <= 1'b0;
            cur_right <= 1'b0;
            pos       <= '0;
            len       <= '0;
            hold_l    <= '0;
            hold_r    <= '0;
            sdo       <= 1'b0;
        end else if (fall_evt) begin
            ws_d1    <= ws_s;
            eff_last <= ws_eff;
            pos      <= p_n;
            sdo      <= bit_n;
            if (slot_edge) begin
                len       <= len_n;
                len_ok    <= lok_n;
                started   <= 1'b1;
                cur_right <= ws_eff;
                if (!ws_eff) begin
                    hold_l <= tx_left;
                    hold_r <= tx_right;
                end
            end
        end
    end
endmodule

// File: rtl/sap_port.sv
// Top of the slave serial audio port: input synchroniser, receiver and
// transmitter sharing one format code. Assumes the system clock is at
// least six times faster than the bit clock.
module sap_port #(
    parameter int WORD_W      = 20,
    parameter int SLOT_MAX    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fmt,
    input  logic              sck,
    input  logic              ws,
    input  logic              sdi,
    output logic              sdo,
    input  logic [WORD_W-1:0] tx_left,
    input  logic [WORD_W-1:0] tx_right,
    output logic [WORD_W-1:0] rx_left,
    output logic [WORD_W-1:0] rx_right,
    output logic              rx_valid
);
    logic rise_evt;
    logic fall_evt;
    logic ws_s;
    logic sdi_s;

    sap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sdi(sdi),
        .rise_evt(rise_evt), .fall_evt(fall_evt), .ws_s(ws_s), .sdi_s(sdi_s)
    );

    sap_rx #(.WORD_W(WORD_W), .SLOT_MAX(SLOT_MAX)) u_rx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .rise_evt(rise_evt),
        .ws_s(ws_s), .sdi_s(sdi_s),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    sap_tx #(.WORD_W(WORD_W), .SLOT_MAX(SLOT_MAX)) u_tx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .fall_evt(fall_evt),
        .ws_s(ws_s), .tx_left(tx_left), .tx_right(tx_right), .sdo(sdo)
    );
endmodule

// File: rtl/sap_port_chk.sv
// Property checker for the serial audio port, bound into every instance.
// Assumes fmt changes only while reset is held.
module sap_port_chk #(
    parameter int WORD_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        fmt,
    input logic              sdo,
    input logic [WORD_W-1:0] rx_left,
    input logic [WORD_W-1:0] rx_right,
    input logic              rx_valid,
    input logic              rise_evt,
    input logic              fall_evt
);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r6_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rise_evt));

    a_r6_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

    a_r7_sdo_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall_evt));

    a_r1_unused_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt) >= 3'd5) |-> !rx_valid);

    a_r9_unused_sdo_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fall_evt) && ($past(fmt) >= 3'd5)) |-> !sdo);
endmodule

bind sap_port sap_port_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .sdo(sdo),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
);

// File: tb/sim_sap_port.sv
module sim_sap_port;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fmt = 3'd4;
    logic        sck = 1'b1;
    logic        ws = 1'b1;
    logic        sdi = 1'b0;
    logic [19:0] tx_left = '0;
    logic [19:0] tx_right = '0;
    logic        sdo;
    logic [19:0] rx_left;
    logic [19:0] rx_right;
    logic        rx_valid;

    int n_checks = 0;
    int n_errors = 0;
    int vcount = 0;

    always #4 clk = ~clk;

    sap_port u0 (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .sck(sck), .ws(ws), .sdi(sdi),
        .sdo(sdo), .tx_left(tx_left), .tx_right(tx_right),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
    );

    // Count receive strobes
    always @(posedge clk) if (rst_n && rx_valid) vcount <= vcount + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    // Word bit index (0 = MSB) carried at slot position p, or -1
    function automatic int pos_of(input logic [2:0] f, input int len, input int p);
        int n;
        case (f)
            3'd0: return (p >= 1 && p <= 20) ? p - 1 : -1;
            3'd4: return (p < 20) ? p : -1;
            3'd1, 3'd2, 3'd3: begin
                n = (f == 3'd1) ? 16 : (f == 3'd2) ? 18 : 20;
                return (p >= len - n) ? p - (len - n) : -1;
            end
            default: return -1;
        endcase
    endfunction

    function automatic logic [19:0] keep_mask(input logic [2:0] f);
        case (f)
            3'd0, 3'd3, 3'd4: return 20'hFFFFF;
            3'd1: return 20'hFFFF0;
            3'd2: return 20'hFFFFC;
            default: return 20'h00000;
        endcase
    endfunction

    // One bit clock: drive on the falling phase, sample sdo at the rise
    task automatic bit_cycle(input logic w, input logic d, output logic so);
        sck = 1'b0;
        ws  = w;
        sdi = d;
        repeat (HALF) @(negedge clk);
        so  = sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] f);
        fmt = f;
        ws = 1'b1; sck = 1'b1; sdi = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        vcount = 0;
    endtask

    task automatic t_reset();
        tx_left = 20'hFFFFF; tx_right = 20'hFFFFF;
        do_reset(3'd4);
        check("R11 sdo", {31'd0, sdo}, 32'd0);
        check("R11 rx_valid", {31'd0, rx_valid}, 32'd0);
        check("R11 rx_left", {12'd0, rx_left}, 32'd0);
        check("R11 rx_right", {12'd0, rx_right}, 32'd0);
    endtask

    // Run frames as the master and check both directions
    task automatic run_case(input string rtag, input string ttag, input logic [2:0] f,
                            input int len, input int frames,
                            input logic [19:0] l, input logic [19:0] r,
                            input logic [19:0] tl, input logic [19:0] tr,
                            input bit swap);
        logic so;
        logic [19:0] got_l;
        logic [19:0] got_r;
        logic [19:0] m;
        int stray;
        int k;
        logic [19:0] w;
        got_l = '0; got_r = '0; stray = 0;
        tx_left = tl; tx_right = tr;
        do_reset(f);
        for (int p = 0; p < len; p++) bit_cycle(1'b1, 1'b0, so);
        for (int fr = 0; fr < frames; fr++) begin
            for (int s = 0; s < 2; s++) begin
                w = (s == 1) ? r : l;
                for (int p = 0; p < len; p++) begin
                    k = pos_of(f, len, p);
                    if (swap && fr == frames - 1 && s == 0 && p == 4) begin
                        tx_left = ~tl; tx_right = ~tr;
                    end
                    bit_cycle(s == 1, (k >= 0) ? w[19-k] : 1'b0, so);
                    if (fr == frames - 1) begin
                        if (k >= 0) begin
                            if (s == 1) got_r[19-k] = so;
                            else        got_l[19-k] = so;
                        end else if (so) begin
                            stray++;
                        end
                    end
                end
            end
        end
        for (int p = 0; p < 3; p++) bit_cycle(1'b0, 1'b0, so);
        repeat (20) @(negedge clk);
        m = keep_mask(f);
        check({rtag, " rx_left"}, {12'd0, rx_left}, {12'd0, l & m});
        check({rtag, " rx_right"}, {12'd0, rx_right}, {12'd0, r & m});
        check("R6 strobe count", vcount, (m == 0) ? 0 : frames);
        check({ttag, " tx left word"}, {12'd0, got_l}, {12'd0, tl & m});
        check({ttag, " tx right word"}, {12'd0, got_r}, {12'd0, tr & m});
        check("R9 bits outside window", stray, 0);
    endtask

    initial begin
        t_reset();
        run_case("R2 R4", "R7", 3'd4, 32, 3, 20'hA5C3F, 20'h1234B, 20'hC0FFE, 20'h5A5A5, 1'b0);
        run_case("R3", "R7", 3'd0, 32, 3, 20'h8F00D, 20'h7BEEF, 20'h3C3C3, 20'hE1E1F, 1'b0);
        run_case("R3", "R7", 3'd0, 24, 2, 20'hFFFFF, 20'h80001, 20'h00001, 20'hFFFFE, 1'b0);
        run_case("R5", "R8", 3'd1, 32, 3, 20'hBEEF0, 20'h4321F, 20'h9ABCD, 20'h6789F, 1'b0);
        run_case("R5", "R8", 3'd2, 24, 3, 20'hD5557, 20'h2AAAB, 20'hFFFFF, 20'h80003, 1'b0);
        run_case("R5", "R8", 3'd3, 32, 3, 20'hF0F0F, 20'h0F0F1, 20'h13579, 20'hECA86, 1'b0);
        run_case("R4", "R10", 3'd4, 24, 2, 20'h55AA5, 20'hAA55A, 20'h87654, 20'h0F1E2, 1'b1);
        run_case("R1", "R1", 3'd6, 32, 2, 20'hFFFFF, 20'hABCDE, 20'hFFFFF, 20'h12345, 1'b0);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end
endmodule